// File: doc/BRIEF.md
# QPSK Symbol-Rate Carrier Phase Tracking Loop

This block tracks the carrier phase of a QPSK signal. It takes one complex matched-filter sample per symbol. Each sample is derotated by the current phase estimate, which comes from a phase accumulator through a sine/cosine table. A decision-directed detector compares the derotated sample with its hard decision. The resulting error drives a proportional-plus-integral filter, and the filter output advances the accumulator. The loop is second order.

The loop runs continuously from reset and needs no frame timing. Acquisition can take a large share of the incoming stream. The loop filter output is brought out so that acquisition time can be measured. QPSK has fourfold symmetry, so the loop settles at one of four points spaced a quarter turn apart. Resolving that ambiguity is left to a later stage. The gains come from configuration inputs. At the default widths, k1 = 1109 and k2 = 30 give a noise bandwidth of 0.02 of the symbol rate and a damping of 0.7071 for a per-axis amplitude near 1000.

Top module: `qpsk_phase_loop`

## Requirements
- R1: While rstN is low, outValid, outI, outQ, outDec, lfOut, the integrator and the phase accumulator are all zero.
- R2: On a strobe, the block computes the derotated sample from the phase accumulator value held before that strobe. With c = cos and s = sin of that phase, outI = (I*c + Q*s + 2^(CW-2)) >>> (CW-1) and outQ = (Q*c - I*s + 2^(CW-2)) >>> (CW-1). The trig values are round(2^(CW-1)-1 times the function) at angle 2*pi*n/2^AW, where n is the top AW bits of the accumulator.
- R3: Both derotated outputs saturate to the range -2^(DW-1) to 2^(DW-1)-1.
- R4: outDec bit 1 is 1 when outI is negative, and outDec bit 0 is 1 when outQ is negative.
- R5: The phase error is e = outQ*sgn(outI) - outI*sgn(outQ), where sgn(0) = +1.
- R6: The proportional term is (k1*e) >>> SH, and the integrator adds (k2*e) >>> SH. lfOut equals the proportional term plus the updated integrator. Gains are taken in the strobe cycle.
- R7: The phase accumulator adds lfOut on each strobe. The accumulator and the integrator both wrap modulo 2^PW, which is one full turn.
- R8: In a cycle without a strobe, every output and all loop state keep their values, and outValid is low.
- R9: Results of a strobe appear on the next clock edge, together with outValid held high for exactly that one cycle.
- R10: With k1 = 1109, k2 = 30 and a static carrier phase offset, the loop locks. After 550 symbols, the decisions match the sent symbols up to one fixed multiple of 90 degrees, and |lfOut| stays below 300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | One pulse per symbol sample |
| inI | input | DW | In-phase matched-filter sample, signed |
| inQ | input | DW | Quadrature matched-filter sample, signed |
| k1 | input | GW | Proportional gain, signed |
| k2 | input | GW | Integral gain, signed |
| outValid | output | 1 | Marks new results |
| outI | output | DW | Derotated in-phase sample |
| outQ | output | DW | Derotated quadrature sample |
| outDec | output | 2 | Hard decision sign bits |
| lfOut | output | PW | Loop filter output, in phase accumulator units |

## Verification
Every result of a strobe is registered at the same edge that takes in the strobe. Derotated samples, decisions, filter output and the phase step are therefore all due one clock later. The bench drives inputs on the falling edge and reads outputs on the next falling edge. It predicts each value with a fixed-point model that is advanced only on strobe cycles. In gap cycles it checks that every output equals the previous result. The state hold shows up in the next strobe's value, which must match a model that did not advance.

// File: rtl/qpsk_loop_pkg.sv
package qpsk_loop_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // update integrator and phase accumulator
    logic capture;   // load the output registers
  } loopCtl_t;
endpackage

// File: rtl/qpsk_sincos.sv
module qpsk_sincos #(
  parameter int AW = 8,
  parameter int CW = 12
) (
  input  logic [AW-1:0]        angle,
  output logic signed [CW-1:0] sinOut,
  output logic signed [CW-1:0] cosOut
);
  localparam int  RW  = AW - 2;
  localparam int  QN  = 2 ** RW;
  localparam real AMP = real'((2 ** (CW - 1)) - 1);
  localparam logic [RW:0]   QNV = {1'b1, {RW{1'b0}}};
  localparam logic [AW-1:0] QTR = {2'b01, {RW{1'b0}}};

  function automatic int quarterVal(int k);
    real ang;
    ang = 6.283185307179586 * real'(k) / real'(4 * QN);
    return $rtoi(AMP * $sin(ang) + 0.5);
  endfunction

  logic [CW-2:0] tbl [QN+1];

  for (genvar k = 0; k <= QN; k++) begin : g_tbl
    localparam int VI = quarterVal(k);
    localparam logic [CW-2:0] V = VI[CW-2:0];
    assign tbl[k] = V;
  end

  function automatic logic signed [CW-1:0] lookup(input logic [AW-1:0] a);
    logic [RW:0]   ix;
    logic [CW-2:0] m;
    ix = a[AW-2] ? (QNV - {1'b0, a[RW-1:0]}) : {1'b0, a[RW-1:0]};
    m  = tbl[ix];
    return a[AW-1] ? -$signed({1'b0, m}) : $signed({1'b0, m});
  endfunction

  always_comb begin
    sinOut = lookup(angle);
    cosOut = lookup(angle + QTR);
  end
endmodule

// File: rtl/qpsk_loop_ctrl.sv
module qpsk_loop_ctrl
  import qpsk_loop_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     symValid,
  output loopCtl_t ctl,
  output logic     outValid
);
  always_comb begin
    ctl.advance = symValid;
    ctl.capture = symValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= symValid;
  end
endmodule

// File: rtl/qpsk_loop_dp.sv
module qpsk_loop_dp
  import qpsk_loop_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int PW = 16,
  parameter int GW = 16,
  parameter int AW = 8,
  parameter int SH = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  loopCtl_t             ctl,
  input  logic signed [DW-1:0] inI,
  input  logic signed [DW-1:0] inQ,
  input  logic signed [GW-1:0] k1,
  input  logic signed [GW-1:0] k2,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ,
  output logic [1:0]           outDec,
  output logic signed [PW-1:0] lfOut,
  output logic [PW-1:0]        phaseAcc
);
  localparam int PRW = DW + CW + 1;
  localparam int EW  = DW + 2;
  localparam int KW  = GW + EW;
  localparam logic signed [PRW-1:0] HALF = PRW'(1) <<< (CW - 2);
  localparam logic signed [PRW-1:0] TOPV = PRW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PRW-1:0] BOTV = -TOPV - PRW'(1);

  logic signed [CW-1:0] sinV, cosV;
  logic signed [PRW-1:0] accI, accQ;
  logic signed [DW-1:0]  yI, yQ;
  logic signed [EW-1:0]  exI, exQ, termA, termB, errV;
  logic [PW-1:0] integ, propV, intNext, lfV, phaseNext;

  qpsk_sincos #(.AW(AW), .CW(CW)) trig_i (
    .angle (phaseAcc[PW-1 -: AW]),
    .sinOut(sinV),
    .cosOut(cosV)
  );

  function automatic logic signed [DW-1:0] roundSat(input logic signed [PRW-1:0] v);
    logic signed [PRW-1:0] r;
    r = (v + HALF) >>> (CW - 1);
    if (r > TOPV) return TOPV[DW-1:0];
    if (r < BOTV) return BOTV[DW-1:0];
    return r[DW-1:0];
  endfunction

  always_comb begin
    // derotate by the current estimate
    accI = PRW'(inI) * PRW'(cosV) + PRW'(inQ) * PRW'(sinV);
    accQ = PRW'(inQ) * PRW'(cosV) - PRW'(inI) * PRW'(sinV);
    yI   = roundSat(accI);
    yQ   = roundSat(accQ);
    // decision-directed error, sign of zero taken as positive
    exI   = EW'(yI);
    exQ   = EW'(yQ);
    termA = yI[DW-1] ? -exQ : exQ;
    termB = yQ[DW-1] ? -exI : exI;
    errV  = termA - termB;
    // proportional-plus-integral filter, modulo arithmetic
    propV     = PW'((KW'(k1) * KW'(errV)) >>> SH);
    intNext   = integ + PW'((KW'(k2) * KW'(errV)) >>> SH);
    lfV       = propV + intNext;
    phaseNext = phaseAcc + lfV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ    <= '0;
      phaseAcc <= '0;
      outI     <= '0;
      outQ     <= '0;
      outDec   <= '0;
      lfOut    <= '0;
    end else begin
      if (ctl.advance) begin
        integ    <= intNext;
        phaseAcc <= phaseNext;
      end
      if (ctl.capture) begin
        outI   <= yI;
        outQ   <= yQ;
        outDec <= {yI[DW-1], yQ[DW-1]};
        lfOut  <= lfV;
      end
    end
  end
endmodule

// File: rtl/qpsk_phase_loop.sv
module qpsk_phase_loop
  import qpsk_loop_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int PW = 16,
  parameter int GW = 16,
  parameter int AW = 8,
  parameter int SH = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 symValid,
  input  logic signed [DW-1:0] inI,
  input  logic signed [DW-1:0] inQ,
  input  logic signed [GW-1:0] k1,
  input  logic signed [GW-1:0] k2,
  output logic                 outValid,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ,
  output logic [1:0]           outDec,
  output logic signed [PW-1:0] lfOut
);
  loopCtl_t      ctl;
  logic [PW-1:0] phaseAcc;

  qpsk_loop_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .symValid(symValid),
    .ctl     (ctl),
    .outValid(outValid)
  );

  qpsk_loop_dp #(
    .DW(DW), .CW(CW), .PW(PW), .GW(GW), .AW(AW), .SH(SH)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inI     (inI),
    .inQ     (inQ),
    .k1      (k1),
    .k2      (k2),
    .outI    (outI),
    .outQ    (outQ),
    .outDec  (outDec),
    .lfOut   (lfOut),
    .phaseAcc(phaseAcc)
  );
endmodule

// File: rtl/qpsk_loop_chk.sv
module qpsk_loop_chk #(
  parameter int DW = 12,
  parameter int PW = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 symValid,
  input logic                 outValid,
  input logic signed [DW-1:0] outI,
  input logic signed [DW-1:0] outQ,
  input logic [1:0]           outDec,
  input logic signed [PW-1:0] lfOut,
  input logic [PW-1:0]        phaseAcc
);
  // R1: state is clear after any cycle in reset
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && lfOut == '0 && phaseAcc == '0 && outDec == 2'b00));

  // R4: decision bits follow the signs of the derotated sample
  p_dec_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outDec == {outI[DW-1], outQ[DW-1]}));

  // R7: accumulator advanced by exactly the reported filter output, modulo a turn
  p_phase_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (phaseAcc == $past(phaseAcc) + $unsigned(lfOut)));

  // R8: no strobe, nothing moves
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> ($stable(outI) && $stable(outQ) && $stable(outDec)
                   && $stable(lfOut) && $stable(phaseAcc) && !outValid));

  // R9: one result pulse per strobe, one cycle later
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    symValid |=> outValid);
endmodule

bind qpsk_phase_loop qpsk_loop_chk #(.DW(DW), .PW(PW)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .symValid(symValid),
  .outValid(outValid),
  .outI    (outI),
  .outQ    (outQ),
  .outDec  (outDec),
  .lfOut   (lfOut),
  .phaseAcc(phaseAcc)
);

// File: tb/qpsk_phase_loop_tb_top.sv
`timescale 1ns/1ps
module qpsk_phase_loop_tb_top;
  localparam int DW = 12;
  localparam int PW = 16;
  localparam int GW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0;
  logic signed [DW-1:0] inI = '0;
  logic signed [DW-1:0] inQ = '0;
  logic signed [GW-1:0] k1 = '0;
  logic signed [GW-1:0] k2 = '0;
  logic outValid;
  logic signed [DW-1:0] outI, outQ;
  logic [1:0] outDec;
  logic signed [PW-1:0] lfOut;

  always #4 clk = ~clk;

  qpsk_phase_loop dut_i (
    .clk(clk), .rstN(rstN), .symValid(symValid), .inI(inI), .inQ(inQ),
    .k1(k1), .k2(k2), .outValid(outValid), .outI(outI), .outQ(outQ),
    .outDec(outDec), .lfOut(lfOut)
  );

  int nChecks = 0;
  int nBad = 0;
  longint mPhase = 0, mInteg = 0;
  longint lastI = 0, lastQ = 0, lastLf = 0, lastDec = 0;

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic longint trig(longint n);
    return longint'(rnd(2047.0 * $sin(6.283185307179586 * real'(n % 256) / 256.0)));
  endfunction

  function automatic longint rsat(longint v);
    longint r;
    r = (v + 1024) >>> 11;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  function automatic int quadOf(longint d);
    case (d)
      0: return 0;
      2: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic doStep(int i, int q, bit v);
    longint c, s, yI, yQ, e, prop, lf, idx;
    inI = DW'(i);
    inQ = DW'(q);
    symValid = v;
    if (v) begin
      idx = mPhase >> 8;
      s = trig(idx);
      c = trig((idx + 64) % 256);
      yI = rsat(longint'(i) * c + longint'(q) * s);
      yQ = rsat(longint'(q) * c - longint'(i) * s);
      e = ((yI < 0) ? -yQ : yQ) - ((yQ < 0) ? -yI : yI);
      prop = ((longint'(k1) * e) >>> 12) & 'hFFFF;
      mInteg = (mInteg + ((longint'(k2) * e) >>> 12)) & 'hFFFF;
      lf = (prop + mInteg) & 'hFFFF;
      mPhase = (mPhase + lf) & 'hFFFF;
      lastI = yI; lastQ = yQ; lastLf = lf;
      lastDec = ((yI < 0) ? 2 : 0) + ((yQ < 0) ? 1 : 0);
    end
    @(posedge clk);
    @(negedge clk);
    symValid = 1'b0;
    if (v) begin
      check("R9", "outValid after strobe", longint'(outValid), 1);
      check("R2", "outI", longint'(outI), lastI);
      check("R2", "outQ", longint'(outQ), lastQ);
      check("R4", "outDec", longint'(outDec), lastDec);
      check("R5,R6", "lfOut", longint'($unsigned(lfOut)), lastLf);
    end else begin
      check("R8", "outValid without strobe", longint'(outValid), 0);
      check("R8", "outI held", longint'(outI), lastI);
      check("R8", "outQ held", longint'(outQ), lastQ);
      check("R8", "outDec held", longint'(outDec), lastDec);
      check("R8", "lfOut held", longint'($unsigned(lfOut)), lastLf);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "outValid in reset", longint'(outValid), 0);
    check("R1", "outI in reset", longint'(outI), 0);
    check("R1", "outQ in reset", longint'(outQ), 0);
    check("R1", "outDec in reset", longint'(outDec), 0);
    check("R1", "lfOut in reset", longint'(lfOut), 0);
    rstN = 1'b1;
    mPhase = 0; mInteg = 0;
    lastI = 0; lastQ = 0; lastLf = 0; lastDec = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nChecks + 1, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    doReset();

    // saturation toward the negative limit after the phase wraps below zero
    k1 = 16'sd16400; k2 = 16'sd0;
    doStep(2047, 0, 1'b1);            // phase jumps to -45 degrees
    doStep(-2048, -2048, 1'b1);
    check("R3", "negative saturation outQ", longint'(outQ), -2048);
    check("R7", "wrapped phase gives outI", longint'(outI), 0);

    doReset();
    doStep(2047, 0, 1'b1);
    doStep(2047, 2047, 1'b1);
    check("R3", "positive saturation outQ", longint'(outQ), 2047);
    check("R7", "wrapped phase gives outI", longint'(outI), 0);

    // hold between strobes, with gains disturbed in the gaps
    k1 = 16'sd1109; k2 = 16'sd30;
    doStep(800, 300, 1'b1);
    for (int g = 0; g < 4; g++) begin
      k1 = GW'($urandom);
      k2 = GW'($urandom);
      doStep(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, 1'b0);
    end
    k1 = 16'sd1109; k2 = 16'sd30;
    doStep(-700, 900, 1'b1);          // model did not advance in the gaps

    // acquisition and tracking with a static phase offset (R10)
    begin
      real phi;
      int refK;
      phi = 37.0 * 3.141592653589793 / 180.0;
      refK = 0;
      for (int n = 0; n < 700; n++) begin
        int gaps, bI, bQ, i, q, txQ, rxQ;
        real aI, aQ;
        gaps = int'($urandom_range(0, 2));
        for (int g = 0; g < gaps; g++)
          doStep(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, 1'b0);
        bI = int'($urandom_range(0, 1));
        bQ = int'($urandom_range(0, 1));
        aI = bI ? -1000.0 : 1000.0;
        aQ = bQ ? -1000.0 : 1000.0;
        i = rnd(aI * $cos(phi) - aQ * $sin(phi)) + int'($urandom_range(0, 40)) - 20;
        q = rnd(aI * $sin(phi) + aQ * $cos(phi)) + int'($urandom_range(0, 40)) - 20;
        doStep(i, q, 1'b1);
        txQ = quadOf(longint'(bI * 2 + bQ));
        rxQ = quadOf(longint'(outDec));
        if (n == 550) refK = (rxQ - txQ + 4) % 4;
        if (n > 550)
          check("R10", "decision rotation after lock", longint'((rxQ - txQ + 4) % 4), longint'(refK));
      end
      check("R10", "lfOut small after lock",
            longint'((lfOut < 0 ? -lfOut : lfOut) < 300), 1);
    end

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule